// File: doc/BRIEF.md
# Boot Source Capture and Address Aliasing

This block decides where the processor boots from. Two strap pins are sampled a fixed number of system-clock edges after reset is released. The same capture sequence runs again whenever the chip leaves its standby state. The captured pin pair is decoded into one of three boot memories: user flash, system memory or embedded SRAM. Until the capture is complete, a hold output keeps the processor from fetching.

Once a source is latched, bus addresses in the 32-Mbyte boot window at address zero are redirected to the chosen memory. The redirect adds the window offset to that memory's native base. Addresses outside the window pass through unchanged, so the selected memory can still be reached at its own native range. The pins go through a two-flop synchronizer before the capture register. Only the pin value present two edges before capture is used.

Top module: `boot_alias_top`

## Requirements
- R1: While reset is asserted and directly after its release, `cpu_hold` is 1, `sel_valid` is 0 and `boot_sel` is 0 (user flash).
- R2: The pins are captured on the 4th rising clock edge after reset release. `cpu_hold` stays 1 after edges 1 to 3 and is 0 after edge 4. `sel_valid` is always the inverse of `cpu_hold`.
- R3: The `boot_sel` encoding is 0 for user flash, 1 for system memory and 2 for embedded SRAM. `boot_pin0`=0 gives 0 whatever `boot_pin1` is. `boot_pin1`=0 with `boot_pin0`=1 gives 1. Both pins at 1 give 2.
- R4: A `standby_exit` pulse sampled on edge E sets `cpu_hold` after E. The pins are then captured again on the 4th rising edge after E.
- R5: Once capture is complete, later pin changes have no effect on `boot_sel`. The value holds until the next reset or standby exit.
- R6: A bus address with bits [31:25] all zero lies in the boot window. Its translated address is the base of the selected memory plus `bus_addr[24:0]`. The bases are 0x0800_0000 for flash, 0x1FFF_F000 for system memory and 0x2000_0000 for SRAM.
- R7: An address outside the boot window is output unchanged, so every memory stays reachable at its native range.
- R8: The captured value is the pin level sampled on the 2nd rising edge before the capture edge. A pin change after that edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_exit | input | 1 | One-cycle pulse when leaving standby; restarts capture |
| boot_pin0 | input | 1 | Boot strap pin, low bit |
| boot_pin1 | input | 1 | Boot strap pin, high bit |
| bus_addr | input | 32 | Address from the processor bus |
| boot_sel | output | 2 | Latched boot memory (0 flash, 1 system, 2 SRAM) |
| mapped_addr | output | 32 | Address after boot-window translation |
| sel_valid | output | 1 | Capture complete; `boot_sel` is meaningful |
| cpu_hold | output | 1 | Holds the processor until capture completes |

## Verification
The assertions assume that `standby_exit` is a single-cycle pulse. They also assume the strap pins change only at the falling clock edge, so every value that reaches the synchronizer is a clean level. The bench drives every input at the falling edge and keeps pins steady across each reset, except in the deliberate R8 cases. In those cases the pins flip just before or just after the second post-reset edge, to show exactly which sample reaches the capture register. The address sweep is run once per decoded source. It covers window offsets at zero, at the top of the window and at a mid value, plus native addresses on both sides of the window edge.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

   typedef enum logic [1:0] {
      SRC_FLASH  = 2'd0,
      SRC_SYSMEM = 2'd1,
      SRC_SRAM   = 2'd2
   } boot_src_e;

   // strap pair -> memory: low pin clear means flash
   function automatic boot_src_e strap_to_src(input logic hi, input logic lo);
      if (!lo)      return SRC_FLASH;
      else if (!hi) return SRC_SYSMEM;
      else          return SRC_SRAM;
   endfunction

endpackage

// File: rtl/boot_pin_sync.sv
module boot_pin_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] pin_o
);

   initial begin : prm_chk
      assert (STAGES >= 2 && WIDTH >= 1)
         else $error("boot_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= pin_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign pin_o = stg[STAGES-1];

endmodule

// File: rtl/boot_capture.sv
module boot_capture
   import boot_alias_pkg::*;
#(
   parameter int CAPTURE_EDGE = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart_i,
   input  logic [1:0] pins_i,
   output boot_src_e sel_o,
   output logic      busy_o
);

   localparam int CW = (CAPTURE_EDGE > 2) ? $clog2(CAPTURE_EDGE) : 1;
   localparam logic [CW-1:0] LAST = CW'(CAPTURE_EDGE - 1);

   initial begin : prm_chk
      assert (CAPTURE_EDGE >= 2)
         else $error("boot_capture: CAPTURE_EDGE must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          busy;
   boot_src_e     sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b1;
         cnt   <= '0;
         sel_q <= SRC_FLASH;
      end else if (restart_i) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAST) begin
            sel_q <= strap_to_src(pins_i[1], pins_i[0]);
            busy  <= 1'b0;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign sel_o  = sel_q;
   assign busy_o = busy;

   // R4
   restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> busy);

   // R5
   sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !restart_i) |=> (!busy && $stable(sel_q)));

endmodule

// File: rtl/boot_addr_map.sv
module boot_addr_map
   import boot_alias_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          REGION_BITS = 25,
   parameter logic [31:0] FLASH_BASE  = 32'h0800_0000,
   parameter logic [31:0] SYSMEM_BASE = 32'h1FFF_F000,
   parameter logic [31:0] SRAM_BASE   = 32'h2000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  boot_src_e         sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int TAG_W = ADDR_W - REGION_BITS;

   initial begin : prm_chk
      assert (REGION_BITS > 0 && REGION_BITS < ADDR_W && ADDR_W <= 32)
         else $error("boot_addr_map: boot window must be narrower than the address");
   end

   logic              in_window;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] base;

   assign in_window = (addr_i[ADDR_W-1:REGION_BITS] == '0);
   assign offset    = {{TAG_W{1'b0}}, addr_i[REGION_BITS-1:0]};

   always_comb begin
      unique case (sel_i)
         SRC_SYSMEM: base = SYSMEM_BASE[ADDR_W-1:0];
         SRC_SRAM:   base = SRAM_BASE[ADDR_W-1:0];
         default:    base = FLASH_BASE[ADDR_W-1:0];
      endcase
   end

   assign addr_o = in_window ? (base + offset) : addr_i;

   // R6
   alias_leaves_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |-> (addr_o[ADDR_W-1:REGION_BITS] != '0));

   // R7
   native_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i[ADDR_W-1:REGION_BITS] != '0) |-> (addr_o == addr_i));

endmodule

// File: rtl/boot_alias_top.sv
module boot_alias_top
   import boot_alias_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          REGION_BITS  = 25,
   parameter int          CAPTURE_EDGE = 4,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [31:0] FLASH_BASE   = 32'h0800_0000,
   parameter logic [31:0] SYSMEM_BASE  = 32'h1FFF_F000,
   parameter logic [31:0] SRAM_BASE    = 32'h2000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_exit,
   input  logic              boot_pin0,
   input  logic              boot_pin1,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        boot_sel,
   output logic [ADDR_W-1:0] mapped_addr,
   output logic              sel_valid,
   output logic              cpu_hold
);

   initial begin : prm_chk
      assert (CAPTURE_EDGE > SYNC_STAGES)
         else $error("boot_alias_top: capture edge must follow the synchronizer");
   end

   logic [1:0] pins_sync;
   boot_src_e  sel;
   logic       busy;

   boot_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i ({boot_pin1, boot_pin0}),
      .pin_o (pins_sync)
   );

   boot_capture #(.CAPTURE_EDGE(CAPTURE_EDGE)) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (standby_exit),
      .pins_i    (pins_sync),
      .sel_o     (sel),
      .busy_o    (busy)
   );

   boot_addr_map #(
      .ADDR_W      (ADDR_W),
      .REGION_BITS (REGION_BITS),
      .FLASH_BASE  (FLASH_BASE),
      .SYSMEM_BASE (SYSMEM_BASE),
      .SRAM_BASE   (SRAM_BASE)
   ) i_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (sel),
      .addr_i (bus_addr),
      .addr_o (mapped_addr)
   );

   assign boot_sel  = sel;
   assign cpu_hold  = busy;
   assign sel_valid = ~busy;

   // checker: length of the current hold window in edges
   localparam int HW = $clog2(CAPTURE_EDGE + 1) + 1;
   logic [HW-1:0] hold_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         hold_run <= '0;
      else if (standby_exit || !cpu_hold) hold_run <= '0;
      else if (hold_run != '1)            hold_run <= hold_run + 1'b1;
   end

   // R2
   hold_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_hold) |-> (hold_run == HW'(CAPTURE_EDGE)));

   // R3
   decode_at_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_hold) |-> (boot_sel == (!$past(pins_sync[0]) ? 2'd0 :
                                        (!$past(pins_sync[1]) ? 2'd1 : 2'd2))));

endmodule

// File: tb/test_boot_alias_top.sv
module test_boot_alias_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby_exit = 1'b0;
   logic        boot_pin0 = 1'b0;
   logic        boot_pin1 = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [1:0]  boot_sel;
   logic [31:0] mapped_addr;
   logic        sel_valid;
   logic        cpu_hold;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   boot_alias_top i_boot_alias_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .standby_exit (standby_exit),
      .boot_pin0    (boot_pin0),
      .boot_pin1    (boot_pin1),
      .bus_addr     (bus_addr),
      .boot_sel     (boot_sel),
      .mapped_addr  (mapped_addr),
      .sel_valid    (sel_valid),
      .cpu_hold     (cpu_hold)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_sel(input logic p1, input logic p0);
      return p0 ? (p1 ? 2'd2 : 2'd1) : 2'd0;
   endfunction

   function automatic logic [31:0] exp_base(input logic [1:0] s);
      case (s)
         2'd1:    return 32'h1FFF_F000;
         2'd2:    return 32'h2000_0000;
         default: return 32'h0800_0000;
      endcase
   endfunction

   // hold through edges 1..3, released after edge 4
   task automatic watch_capture(input string tag);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk(tag, {31'd0, cpu_hold}, (k < 4) ? 32'd1 : 32'd0);
         chk(tag, {31'd0, sel_valid}, (k < 4) ? 32'd0 : 32'd1);
      end
   endtask

   task automatic do_reset(input logic p1, input logic p0);
      @(negedge clk);
      rst_n = 1'b0;
      boot_pin1 = p1;
      boot_pin0 = p0;
      repeat (3) @(negedge clk);
      chk("R1 hold in reset", {31'd0, cpu_hold}, 32'd1);
      chk("R1 valid in reset", {31'd0, sel_valid}, 32'd0);
      chk("R1 sel in reset", {30'd0, boot_sel}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic sweep_addr(input logic [1:0] s);
      logic [31:0] offs [4];
      logic [31:0] natv [4];
      offs = '{32'h0, 32'h4, 32'h01FF_FFFC, 32'h00AB_CDE0};
      natv = '{32'h0200_0000, 32'h0800_0010, 32'h2000_0100, 32'hFFFF_FFFC};
      for (int i = 0; i < 4; i++) begin
         bus_addr = offs[i];
         #1;
         chk("R6 window alias", mapped_addr, exp_base(s) + offs[i]);
         bus_addr = natv[i];
         #1;
         chk("R7 native pass", mapped_addr, natv[i]);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      // R1, R2, R3, R6, R7: every strap combination
      for (int c = 0; c < 4; c++) begin
         do_reset(c[1], c[0]);
         chk("R1 hold at release", {31'd0, cpu_hold}, 32'd1);
         watch_capture("R2 capture edge");
         chk("R3 decode", {30'd0, boot_sel}, {30'd0, exp_sel(c[1], c[0])});
         sweep_addr(exp_sel(c[1], c[0]));
      end

      // R5: pins toggle after capture, selection stays (current: 11 -> SRAM)
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         boot_pin0 = k[0];
         boot_pin1 = k[1];
      end
      repeat (3) @(negedge clk);
      chk("R5 sel kept", {30'd0, boot_sel}, 32'd2);
      chk("R5 valid kept", {31'd0, sel_valid}, 32'd1);

      // R4: standby exit recaptures with pins 01
      boot_pin1 = 1'b0;
      boot_pin0 = 1'b1;
      repeat (4) @(negedge clk);
      standby_exit = 1'b1;
      @(negedge clk);
      standby_exit = 1'b0;
      chk("R4 hold after exit", {31'd0, cpu_hold}, 32'd1);
      watch_capture("R4 recapture edge");
      chk("R4 new sel", {30'd0, boot_sel}, 32'd1);
      sweep_addr(2'd1);

      // R8: change after edge 2 is missed
      do_reset(1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      boot_pin1 = 1'b1;
      boot_pin0 = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 late change ignored", {30'd0, boot_sel}, 32'd0);

      // R8: change before edge 2 is captured
      do_reset(1'b0, 1'b0);
      @(negedge clk);
      boot_pin1 = 1'b1;
      boot_pin0 = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 early change taken", {30'd0, boot_sel}, 32'd2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule